// File: doc/BRIEF.md
# Load-Linked Line Lock Controller

This block is the coherence controller for a single private cache line. It tracks the usual invalid, shared, exclusive and modified states, plus two timed locked states: locked-exclusive and locked-modified. A load-linked that finds the line exclusive or modified locks it in place. A load-linked that misses, or that lacks write permission, requests ownership the same way a store does. When that data arrives, the line is locked. While the line is locked it serves local loads and stores. It stalls every request that would take the line away: external invalidations, forwarded reads, forwarded ownership requests and replacement evictions. This gives the matching store-conditional a window in which it cannot be robbed of the line. Under heavy contention, that window breaks the livelock where other cores keep stealing the line between the load-linked and the store-conditional.

Once the configured number of cycles has passed, the lock lapses. Locked-exclusive falls back to exclusive and locked-modified falls back to modified. Any stalled snoop or held eviction is then serviced normally. A parameter removes the mechanism: with it off, a load-linked is an ordinary load and the locked states never occur. The data array, the directory and the interconnect lie outside this block.

Top module: `llsc_line_ctrl`

## Requirements
- R1: After reset the line state is invalid (code 0), no miss is outstanding, `core_ready` and `snp_ready` are high, and no pulse output is asserted.
- R2: A load (`core_op` 0, or the spare code 3) to an invalid line issues a shared miss. In the cycle after acceptance, `miss_valid` is high and `miss_excl` is 0. `core_ready` stays low until the fill arrives. The fill sets the state to exclusive (2) when `fill_excl` is 1, and to shared (1) otherwise.
- R3: A store (`core_op` 1) or a load-linked (`core_op` 2) to an invalid or shared line issues a miss with `miss_excl` = 1. On the fill, a store leads to modified (3) and a load-linked leads to locked-exclusive (4), whatever the value of `fill_excl`.
- R4: A load-linked hit moves exclusive to locked-exclusive (4) and modified to locked-modified (5). The lock lasts LOCK_CYCLES clock cycles. After that, 4 returns to 2 and 5 returns to 3.
- R5: A store to a locked-exclusive line moves it to locked-modified without restarting the lock time. A load-linked to a locked line restarts the lock time.
- R6: While the line is locked, `snp_ready` is low. Once the lock has lapsed, an accepted snoop acts as follows. An invalidate (`snp_kind` 0, or the spare code 3) or a forwarded ownership request (`snp_kind` 2) leaves the line invalid. A forwarded read (`snp_kind` 1) leaves a valid line shared. `snp_dirty` pulses in the next cycle when the line was modified.
- R7: An eviction request that arrives while the line is locked or a miss is outstanding is held. It is performed once neither condition holds. The line becomes invalid. In the next cycle `evict_wb` pulses for a modified line and `evict_drop` pulses for a shared or exclusive line. Neither pulses for an invalid line.
- R8: With LOCK_EN = 0, a load-linked behaves exactly as a load: it issues a shared miss from invalid, leaves any valid state unchanged, and never reaches codes 4 or 5.
- R9: In one cycle, an accepted snoop takes precedence over a core request (`core_ready` low) and over an eviction (the eviction stays held). A performed eviction takes precedence over a core request.
- R10: A fill that arrives with no miss outstanding has no effect on the line state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_valid | input | 1 | Core request valid |
| core_op | input | 2 | 0 load, 1 store, 2 load-linked, 3 load |
| core_ready | output | 1 | Core request accepted this cycle when valid |
| miss_valid | output | 1 | One-cycle miss request pulse |
| miss_excl | output | 1 | Miss asks for ownership (1) or a shared copy (0) |
| fill_valid | input | 1 | Miss data response |
| fill_excl | input | 1 | Shared-miss data came with exclusive permission |
| snp_valid | input | 1 | External snoop valid |
| snp_kind | input | 2 | 0 invalidate, 1 forwarded read, 2 forwarded ownership, 3 invalidate |
| snp_ready | output | 1 | Snoop accepted this cycle when valid |
| snp_dirty | output | 1 | Pulse: snooped line was modified, data supplied |
| evict_valid | input | 1 | Replacement asks to evict the line |
| evict_wb | output | 1 | Pulse: eviction of a modified line |
| evict_drop | output | 1 | Pulse: eviction of a clean line |
| line_state | output | 3 | Current state code (0 I, 1 S, 2 E, 3 M, 4 locked E, 5 locked M) |

## Verification
The case that needs the most care is a snoop that meets a core request or an eviction in the same cycle. The outcome depends on the lock. On a locked line the store goes through and the snoop waits. On an unlocked line the snoop wins, and the store is refused with `core_ready` low. The bench drives both situations at once: it feeds the same snoop-plus-store stimulus to a lock-enabled instance and a lock-disabled instance. Random traffic then mixes snoops, evictions, fills and core requests at independent rates, so these collisions happen often. A per-instance model decides the expected winner from the requirements and compares every ready signal, pulse and state code.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  typedef enum logic [2:0] {
    ST_I  = 3'd0,
    ST_S  = 3'd1,
    ST_E  = 3'd2,
    ST_M  = 3'd3,
    ST_LE = 3'd4,
    ST_LM = 3'd5
  } line_st_e;

  localparam logic [1:0] OP_LD = 2'd0;
  localparam logic [1:0] OP_ST = 2'd1;
  localparam logic [1:0] OP_LL = 2'd2;

  localparam logic [1:0] SN_INV  = 2'd0;
  localparam logic [1:0] SN_FWDS = 2'd1;
  localparam logic [1:0] SN_FWDX = 2'd2;

  function automatic logic is_locked(line_st_e s);
    return (s == ST_LE) || (s == ST_LM);
  endfunction

  function automatic logic is_dirty(line_st_e s);
    return (s == ST_M) || (s == ST_LM);
  endfunction

  function automatic line_st_e unlock_st(line_st_e s);
    case (s)
      ST_LE:   return ST_E;
      ST_LM:   return ST_M;
      default: return s;
    endcase
  endfunction

  function automatic line_st_e lock_st(line_st_e s);
    case (s)
      ST_E, ST_LE: return ST_LE;
      default:     return ST_LM;
    endcase
  endfunction

  function automatic line_st_e snoop_st(line_st_e s, logic [1:0] kind);
    if (kind == SN_FWDS && s != ST_I) return ST_S;
    return ST_I;
  endfunction

  function automatic line_st_e store_st(line_st_e s);
    return is_locked(s) ? ST_LM : ST_M;
  endfunction

endpackage

// File: rtl/llsc_lock_timer.sv
module llsc_lock_timer #(
  parameter int LOCK_CYCLES = 32,
  localparam int TW = $clog2(LOCK_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic locked,
  input  logic reload,
  output logic expire
);

  localparam logic [TW-1:0] FULL = TW'(LOCK_CYCLES);
  localparam logic [TW-1:0] ONE  = TW'(1);

  logic [TW-1:0] cnt_q;

  assign expire = locked && (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (reload)                 cnt_q <= FULL;
    else if (locked && cnt_q != '0)  cnt_q <= cnt_q - ONE;
    else                             cnt_q <= '0;
  end

  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);

endmodule

// File: rtl/llsc_port_arb.sv
module llsc_port_arb (
  input  logic locked,
  input  logic pend,
  input  logic snp_valid,
  input  logic evict_req,
  input  logic core_valid,
  input  logic fill_valid,
  output logic snp_ready,
  output logic snp_fire,
  output logic evict_do,
  output logic core_ready,
  output logic core_fire,
  output logic fill_fire
);

  assign snp_ready  = !locked;
  assign snp_fire   = snp_valid && snp_ready;
  assign evict_do   = evict_req && !locked && !pend && !snp_fire;
  assign core_ready = !pend && !snp_fire && !evict_do;
  assign core_fire  = core_valid && core_ready;
  assign fill_fire  = fill_valid && pend;

endmodule

// File: rtl/llsc_next_state.sv
module llsc_next_state
  import llsc_pkg::*;
#(
  parameter bit LOCK_EN = 1'b1
) (
  input  line_st_e   st,
  input  logic       pexcl,
  input  logic       ll_flag,
  input  logic       fill_fire,
  input  logic       fill_excl,
  input  logic       snp_fire,
  input  logic [1:0] snp_kind,
  input  logic       evict_do,
  input  logic       core_fire,
  input  logic [1:0] core_op,
  input  logic       expire,
  output line_st_e   ns,
  output logic       reload,
  output logic       miss_issue,
  output logic       miss_excl_n,
  output logic       miss_ll_n,
  output logic       dirty_n,
  output logic       wb_n,
  output logic       drop_n
);

  logic ll_en;
  generate
    if (LOCK_EN) begin : g_lock_on
      assign ll_en = 1'b1;
    end else begin : g_lock_off
      assign ll_en = 1'b0;
    end
  endgenerate

  logic is_store, is_ll, is_load;
  assign is_store = (core_op == OP_ST);
  assign is_ll    = (core_op == OP_LL) && ll_en;
  assign is_load  = !is_store && !is_ll;

  line_st_e pre;

  always_comb begin
    pre         = st;
    reload      = 1'b0;
    miss_issue  = 1'b0;
    miss_excl_n = 1'b0;
    miss_ll_n   = 1'b0;
    dirty_n     = 1'b0;
    wb_n        = 1'b0;
    drop_n      = 1'b0;
    if (fill_fire) begin
      if (pexcl) begin
        pre    = ll_flag ? ST_LE : ST_M;
        reload = ll_flag;
      end else begin
        pre = fill_excl ? ST_E : ST_S;
      end
    end else if (snp_fire) begin
      dirty_n = is_dirty(st);
      pre     = snoop_st(st, snp_kind);
    end else if (evict_do) begin
      wb_n   = is_dirty(st);
      drop_n = (st == ST_S) || (st == ST_E);
      pre    = ST_I;
    end else if (core_fire) begin
      if (is_load) begin
        if (st == ST_I) miss_issue = 1'b1;
      end else if (st == ST_I || st == ST_S) begin
        miss_issue  = 1'b1;
        miss_excl_n = 1'b1;
        miss_ll_n   = is_ll;
      end else if (is_store) begin
        pre = store_st(st);
      end else begin
        pre    = lock_st(st);
        reload = 1'b1;
      end
    end
    ns = pre;
    if (expire && !reload) ns = unlock_st(pre);
  end

endmodule

// File: rtl/llsc_line_ctrl.sv
module llsc_line_ctrl
  import llsc_pkg::*;
#(
  parameter bit LOCK_EN     = 1'b1,
  parameter int LOCK_CYCLES = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       core_valid,
  input  logic [1:0] core_op,
  output logic       core_ready,
  output logic       miss_valid,
  output logic       miss_excl,
  input  logic       fill_valid,
  input  logic       fill_excl,
  input  logic       snp_valid,
  input  logic [1:0] snp_kind,
  output logic       snp_ready,
  output logic       snp_dirty,
  input  logic       evict_valid,
  output logic       evict_wb,
  output logic       evict_drop,
  output logic [2:0] line_state
);

  line_st_e state_q, ns;
  logic pend_q, pexcl_q, ll_q, evp_q;

  logic locked, evict_req, expire, reload;
  logic snp_fire, evict_do, core_fire, fill_fire;
  logic miss_issue, miss_excl_n, miss_ll_n, dirty_n, wb_n, drop_n;

  assign locked     = is_locked(state_q);
  assign evict_req  = evict_valid || evp_q;
  assign line_state = state_q;

  llsc_port_arb u_arb (
    .locked     (locked),
    .pend       (pend_q),
    .snp_valid  (snp_valid),
    .evict_req  (evict_req),
    .core_valid (core_valid),
    .fill_valid (fill_valid),
    .snp_ready  (snp_ready),
    .snp_fire   (snp_fire),
    .evict_do   (evict_do),
    .core_ready (core_ready),
    .core_fire  (core_fire),
    .fill_fire  (fill_fire)
  );

  llsc_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .locked (locked),
    .reload (reload),
    .expire (expire)
  );

  llsc_next_state #(.LOCK_EN(LOCK_EN)) u_ns (
    .st          (state_q),
    .pexcl       (pexcl_q),
    .ll_flag     (ll_q),
    .fill_fire   (fill_fire),
    .fill_excl   (fill_excl),
    .snp_fire    (snp_fire),
    .snp_kind    (snp_kind),
    .evict_do    (evict_do),
    .core_fire   (core_fire),
    .core_op     (core_op),
    .expire      (expire),
    .ns          (ns),
    .reload      (reload),
    .miss_issue  (miss_issue),
    .miss_excl_n (miss_excl_n),
    .miss_ll_n   (miss_ll_n),
    .dirty_n     (dirty_n),
    .wb_n        (wb_n),
    .drop_n      (drop_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_I;
      pend_q     <= 1'b0;
      pexcl_q    <= 1'b0;
      ll_q       <= 1'b0;
      evp_q      <= 1'b0;
      miss_valid <= 1'b0;
      miss_excl  <= 1'b0;
      snp_dirty  <= 1'b0;
      evict_wb   <= 1'b0;
      evict_drop <= 1'b0;
    end else begin
      state_q <= ns;
      if (miss_issue) begin
        pend_q  <= 1'b1;
        pexcl_q <= miss_excl_n;
        ll_q    <= miss_ll_n;
      end else if (fill_fire) begin
        pend_q <= 1'b0;
        ll_q   <= 1'b0;
      end
      evp_q      <= evict_do ? 1'b0 : evict_req;
      miss_valid <= miss_issue;
      miss_excl  <= miss_excl_n;
      snp_dirty  <= dirty_n;
      evict_wb   <= wb_n;
      evict_drop <= drop_n;
    end
  end

  a_r1_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evict_wb, evict_drop, snp_dirty}));
  a_r2_busy_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !core_ready);
  a_r3_miss_single: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |=> !miss_valid);
  a_r3_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    fill_fire |=> !ll_q);
  a_r4_expire_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !reload) |=> !is_locked(state_q));
  a_r6_stall_locked: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !snp_ready);
  a_r9_snoop_first: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_ready) |-> !core_ready);

  generate
    if (!LOCK_EN) begin : g_no_lock_chk
      a_r8_never_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !is_locked(state_q));
    end
  endgenerate

endmodule

// File: tb/sim_llsc_line_ctrl.sv
module sim_llsc_line_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int LK = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic core_v = 1'b0, fill_v = 1'b0, fill_ex = 1'b0, snp_v = 1'b0, ev_v = 1'b0;
  logic [1:0] core_op = 2'd0, snp_k = 2'd0;

  logic       c_rdy[2], s_rdy[2], mv[2], mx[2], sd[2], wb[2], dr[2];
  logic [2:0] st[2];

  int checks = 0, errors = 0;
  bit done = 0;

  int m_st[2], m_pend[2], m_pex[2], m_ll[2], m_cnt[2], m_ev[2];
  int e_miss[2], e_mex[2], e_dirty[2], e_wb[2], e_drop[2];

  always #(CLK_PERIOD/2) clk = ~clk;

  llsc_line_ctrl #(.LOCK_EN(1'b1), .LOCK_CYCLES(LK)) u0 (
    .clk(clk), .rst_n(rst_n), .core_valid(core_v), .core_op(core_op),
    .core_ready(c_rdy[0]), .miss_valid(mv[0]), .miss_excl(mx[0]),
    .fill_valid(fill_v), .fill_excl(fill_ex), .snp_valid(snp_v), .snp_kind(snp_k),
    .snp_ready(s_rdy[0]), .snp_dirty(sd[0]), .evict_valid(ev_v),
    .evict_wb(wb[0]), .evict_drop(dr[0]), .line_state(st[0]));

  llsc_line_ctrl #(.LOCK_EN(1'b0), .LOCK_CYCLES(LK)) u1 (
    .clk(clk), .rst_n(rst_n), .core_valid(core_v), .core_op(core_op),
    .core_ready(c_rdy[1]), .miss_valid(mv[1]), .miss_excl(mx[1]),
    .fill_valid(fill_v), .fill_excl(fill_ex), .snp_valid(snp_v), .snp_kind(snp_k),
    .snp_ready(s_rdy[1]), .snp_dirty(sd[1]), .evict_valid(ev_v),
    .evict_wb(wb[1]), .evict_drop(dr[1]), .line_state(st[1]));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int after_snoop(int s, int k);
    if (k == 1) return (s == 0) ? 0 : 1;
    return 0;
  endfunction

  // Model of one instance; en selects the lock mechanism (R8).
  task automatic model(int i, bit en);
    int locked, sf, evq, evd, crdy, cf, ff, nxt, rl, ll_op, ld_op;
    locked = (m_st[i] >= 4);
    sf   = snp_v && !locked;
    evq  = ev_v || m_ev[i];
    evd  = evq && !locked && !m_pend[i] && !sf;
    crdy = !m_pend[i] && !sf && !evd;
    cf   = core_v && crdy;
    ff   = fill_v && m_pend[i];
    chk($sformatf("R6 snp_ready u%0d", i), s_rdy[i], !locked);
    chk($sformatf("R9 core_ready u%0d", i), c_rdy[i], crdy);
    e_miss[i] = 0; e_mex[i] = 0; e_dirty[i] = 0; e_wb[i] = 0; e_drop[i] = 0;
    nxt = m_st[i]; rl = 0;
    ll_op = en && core_op == 2;
    ld_op = core_op != 1 && !ll_op;
    if (ff) begin
      if (m_pex[i] != 0) begin nxt = m_ll[i] ? 4 : 3; rl = m_ll[i]; end
      else nxt = fill_ex ? 2 : 1;
      m_pend[i] = 0; m_ll[i] = 0;
    end else if (sf) begin
      e_dirty[i] = (m_st[i] == 3);
      nxt = after_snoop(m_st[i], snp_k);
    end else if (evd) begin
      e_wb[i] = (m_st[i] == 3);
      e_drop[i] = (m_st[i] == 1 || m_st[i] == 2);
      nxt = 0;
    end else if (cf) begin
      if (ld_op) begin
        if (m_st[i] == 0) begin e_miss[i] = 1; m_pend[i] = 1; m_pex[i] = 0; m_ll[i] = 0; end
      end else if (m_st[i] <= 1) begin
        e_miss[i] = 1; e_mex[i] = 1; m_pend[i] = 1; m_pex[i] = 1; m_ll[i] = ll_op;
      end else if (!ll_op) begin
        nxt = (m_st[i] >= 4) ? 5 : 3;
      end else begin
        nxt = (m_st[i] == 2 || m_st[i] == 4) ? 4 : 5; rl = 1;
      end
    end
    if (locked && m_cnt[i] == 1 && !rl) begin
      if (nxt == 4) nxt = 2;
      if (nxt == 5) nxt = 3;
    end
    if (rl) m_cnt[i] = LK;
    else if (locked && m_cnt[i] != 0) m_cnt[i] = m_cnt[i] - 1;
    else m_cnt[i] = 0;
    m_ev[i] = evd ? 0 : evq;
    m_st[i] = nxt;
  endtask

  task automatic step();
    #1;
    model(0, 1'b1);
    model(1, 1'b0);
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      chk($sformatf("R4 line_state u%0d", i), st[i], m_st[i]);
      chk($sformatf("R2 miss_valid u%0d", i), mv[i], e_miss[i]);
      if (e_miss[i] != 0) chk($sformatf("R3 miss_excl u%0d", i), mx[i], e_mex[i]);
      chk($sformatf("R6 snp_dirty u%0d", i), sd[i], e_dirty[i]);
      chk($sformatf("R7 evict_wb u%0d", i), wb[i], e_wb[i]);
      chk($sformatf("R7 evict_drop u%0d", i), dr[i], e_drop[i]);
    end
  endtask

  task automatic idle();
    core_v = 0; fill_v = 0; snp_v = 0; ev_v = 0;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog expired actual 0 expected 1");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < 2; i++) begin
      m_st[i] = 0; m_pend[i] = 0; m_pex[i] = 0; m_ll[i] = 0; m_cnt[i] = 0; m_ev[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1: reset state
    for (int i = 0; i < 2; i++) begin
      chk("R1 state after reset", st[i], 0);
      chk("R1 core_ready after reset", c_rdy[i], 1);
      chk("R1 snp_ready after reset", s_rdy[i], 1);
      chk("R1 pulses after reset", {mv[i], sd[i], wb[i], dr[i]}, 0);
    end
    @(negedge clk);

    // R2: load miss then exclusive fill
    core_v = 1; core_op = 0; step(); idle();
    chk("R2 shared miss request", {mv[0], mx[0]}, 2);
    #1 chk("R2 busy while pending", c_rdy[0], 0);
    step();
    fill_v = 1; fill_ex = 1; step(); idle();
    chk("R2 fill to E", st[0], 2);

    // R10: stray fill
    fill_v = 1; fill_ex = 0; step(); idle();
    chk("R10 stray fill ignored", st[0], 2);

    // R4 / R8: load-linked hit
    core_v = 1; core_op = 2; step(); idle();
    chk("R4 LL hit E locks", st[0], 4);
    chk("R8 LL hit is load when off", st[1], 2);

    // R5 / R9: store plus snoop in one cycle
    snp_v = 1; snp_k = 0; core_v = 1; core_op = 1; step();
    core_v = 0;
    chk("R5 store in locked E", st[0], 5);
    chk("R9 snoop beats store", st[1], 0);
    repeat (4) step();
    chk("R4 still locked", st[0], 5);
    step();
    chk("R4 lock lapsed to M", st[0], 3);
    step(); idle();
    chk("R6 held snoop invalidates", st[0], 0);
    chk("R6 dirty on snoop", sd[0], 1);

    // R7: eviction held by lock
    core_v = 1; core_op = 1; step(); idle();
    step();
    fill_v = 1; step(); idle();
    core_v = 1; core_op = 2; step(); idle();
    chk("R4 LL hit M locks", st[0], 5);
    ev_v = 1; step(); idle();
    chk("R7 eviction held", {st[0], wb[0]}, 10);
    chk("R7 unlocked evicts now", wb[1], 1);
    repeat (5) step();
    chk("R7 not yet evicted", st[0], 3);
    step();
    chk("R7 held eviction writes back", {st[0], wb[0]}, 1);

    // R3 / R8: load-linked miss
    core_v = 1; core_op = 2; step(); idle();
    chk("R3 LL miss is exclusive", mx[0], 1);
    chk("R8 LL miss is shared when off", mx[1], 0);
    fill_v = 1; fill_ex = 0; step(); idle();
    chk("R3 LL fill locks E", st[0], 4);
    chk("R8 shared fill", st[1], 1);

    // Random traffic
    for (int n = 0; n < 4000; n++) begin
      core_v  = ($urandom % 100) < 40;
      core_op = 2'($urandom % 4);
      snp_v   = ($urandom % 100) < 12;
      snp_k   = 2'($urandom % 4);
      ev_v    = ($urandom % 100) < 5;
      fill_v  = ($urandom % 100) < ((m_pend[0] != 0 || m_pend[1] != 0) ? 30 : 3);
      fill_ex = 1'($urandom % 2);
      step();
    end
    idle();
    done = 1;
    summary();
    $finish;
  end

endmodule